// File: doc/BRIEF.md
# Byte-Fetch Multicycle Processor Datapath

This block is the 8-bit datapath of a small load/store processor whose instructions are 32 bits wide. The external memory bus is only one byte wide, so an instruction arrives over four cycles. Each byte lane of the instruction register has its own load enable. The datapath holds the program counter, the instruction register, an eight-entry register file, and the operand, memory-data and ALU-result latches. It also holds the ALU and every steering multiplexer: memory address, register-write destination, register-write data, both ALU operands and next program counter.

The block makes no decisions of its own. A separate multicycle controller drives every select and enable. The controller reads back the assembled instruction word and the ALU zero flag to pick its next state. Memory sits outside the block and is reached through an 8-bit address, an 8-bit read-data input and an 8-bit write-data output. Immediates and jump targets are truncated so that they fit the 8-bit address space.

Top module: `bytefetch_datapath`

## Requirements
- R1: Synchronous active-low reset clears the program counter, the instruction register, the A, B, memory-data and ALU-result latches, and every register-file entry to zero.
- R2: When lane enable `ir_we[k]` is 1 at a clock edge, instruction bits [8k+7:8k] take `mem_rdata`. Lanes whose enable is 0 hold their value. `instr` always shows the full 32-bit word.
- R3: Register index 0 reads as zero, and writes to it have no effect. Indexes 8 to 31 of the 5-bit fields also read as zero and ignore writes.
- R4: The first read port is indexed by instruction bits [25:21] and the second by bits [20:16]. The write index is bits [15:11] when `rf_dst_rd` is 1 and bits [20:16] when it is 0. A write lands at the clock edge when `rf_we` is 1.
- R5: Register write data is the ALU-result latch when `rf_src_mdr` is 0 and the memory-data latch when it is 1. The memory-data latch captures `mem_rdata` at every clock edge.
- R6: The first ALU operand is the program counter when `opa_from_reg` is 0 and the A latch when it is 1. The A latch captures read port 1 at every edge.
- R7: The second ALU operand follows `opb_sel`:
  - 00 selects the B latch.
  - 01 selects the constant 1.
  - 10 selects instruction bits [7:0].
  - 11 selects bits [7:0] shifted left by two and truncated to 8 bits.
- R8: `alu_op` selects the operation:
  - 010 adds.
  - 110 subtracts (first operand minus second).
  - 000 is bitwise AND.
  - 001 is bitwise OR.
  - 111 gives 1 when the first operand is less than the second as signed values, and 0 otherwise.
  - Any other code gives 0.
  
  `zero` is 1 exactly when the live ALU result is all zeros.
- R9: The ALU-result latch captures the live ALU result at every edge. `mem_addr` is the program counter when `addr_from_alu` is 0 and the ALU-result latch when it is 1.
- R10: At an edge with `pc_en` = 1, the program counter loads the value picked by `pc_sel`:
  - 00 picks the live ALU result.
  - 01 picks the ALU-result latch.
  - 10 picks {instruction bits [5:0], 2'b00}.
  - 11 picks its own value.
  
  With `pc_en` = 0 it holds.
- R11: `mem_wdata` is the B latch, which captures read port 2 at every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_rdata | input | 8 | Byte read from external memory |
| ir_we | input | 4 | Per-lane instruction register load enables |
| pc_en | input | 1 | Program counter load enable |
| rf_we | input | 1 | Register file write enable |
| rf_dst_rd | input | 1 | Write index from bits [15:11] (1) or [20:16] (0) |
| rf_src_mdr | input | 1 | Write data from memory-data latch (1) or ALU-result latch (0) |
| addr_from_alu | input | 1 | Memory address from ALU-result latch (1) or program counter (0) |
| opa_from_reg | input | 1 | First ALU operand from A latch (1) or program counter (0) |
| opb_sel | input | 2 | Second ALU operand select |
| pc_sel | input | 2 | Next program counter select |
| alu_op | input | 3 | ALU operation code |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data (B latch) |
| instr | output | 32 | Assembled instruction word for the controller |
| zero | output | 1 | Live ALU result is zero |

## Verification
The bench builds the block with its defaults, an 8-bit data path and eight registers. At these values an immediate of 0x20 shifted left by two becomes 0x80. That value is the most negative signed byte, so one stimulus covers both the truncating shift and the signed compare. The same width makes a 6-bit jump field scale to a full 8-bit address. The bench fetches instruction words a byte at a time, both with the program counter stepping and with it frozen. It checks partially filled words, read-before-write timing through the operand latches, the discarded write to register 0, and all four next-PC sources.

// File: rtl/dp_pkg.sv
// Shared encodings for the byte-fetch datapath.
// Assumes a 32-bit instruction split into four byte lanes and fixed
// field positions for the register indexes.
package dp_pkg;

    localparam int IR_BYTES = 4;
    localparam int FIELD_W  = 5;
    localparam int RS_LSB   = 21;
    localparam int RT_LSB   = 16;
    localparam int RD_LSB   = 11;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        OPB_REG  = 2'b00,
        OPB_ONE  = 2'b01,
        OPB_IMM  = 2'b10,
        OPB_IMM4 = 2'b11
    } opb_sel_e;

    typedef enum logic [1:0] {
        PCN_ALU  = 2'b00,
        PCN_OUT  = 2'b01,
        PCN_JMP  = 2'b10,
        PCN_KEEP = 2'b11
    } pc_sel_e;

endpackage

// File: rtl/dp_instr_reg.sv
// Instruction register built from independent byte lanes.
// Each lane loads the memory byte when its own enable is set.
// Assumes the controller raises one lane enable per fetch cycle.
module dp_instr_reg #(
    parameter int W     = 8,
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES-1:0]   lane_we,
    input  logic [W-1:0]       din,
    output logic [LANES*W-1:0] ir_q
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [W-1:0] lane_q;

        // Capture one byte lane when its enable is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (lane_we[k]) begin
                lane_q <= din;
            end
        end

        assign ir_q[k*W +: W] = lane_q;
    end

endmodule

// File: rtl/dp_regfile.sv
// General register file: two combinational read ports, one write port.
// Entry 0 is not stored and reads as zero. Indexes at or above NREGS
// read zero and are never written. Assumes a single clock domain.
module dp_regfile #(
    parameter int W     = 8,
    parameter int NREGS = 8,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wa,
    input  logic [W-1:0]     wd,
    input  logic [IDX_W-1:0] ra1,
    input  logic [IDX_W-1:0] ra2,
    output logic [W-1:0]     rd1,
    output logic [W-1:0]     rd2
);

    localparam int SEL_W = $clog2(NREGS);

    logic [W-1:0] regs [1:NREGS-1];
    logic         wr_hit;

    // A write is accepted only for a real, non-zero entry.
    always_comb wr_hit = we && (wa != '0) && (int'(wa) < NREGS);

    // Store write data; clear every entry on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i < NREGS; i++) begin
                regs[i] <= '0;
            end
        end else if (wr_hit) begin
            regs[wa[SEL_W-1:0]] <= wd;
        end
    end

    // Read port 1, zero for entry 0 and absent entries.
    always_comb begin
        if (ra1 != '0 && int'(ra1) < NREGS) rd1 = regs[ra1[SEL_W-1:0]];
        else                               rd1 = '0;
    end

    // Read port 2, same rules as port 1.
    always_comb begin
        if (ra2 != '0 && int'(ra2) < NREGS) rd2 = regs[ra2[SEL_W-1:0]];
        else                               rd2 = '0;
    end

endmodule

// File: rtl/dp_alu.sv
// Combinational ALU with a zero flag.
// Assumes two's complement operands for the signed compare.
module dp_alu
    import dp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   op,
    output logic [W-1:0] y,
    output logic         zero
);

    // Select the operation result from the control code.
    always_comb begin
        case (alu_op_e'(op))
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            default: y = '0;
        endcase
    end

    // Flag an all-zero result.
    always_comb zero = (y == '0);

endmodule

// File: rtl/bytefetch_datapath.sv
// Multicycle datapath with byte-wide instruction fetch.
// Holds the PC, the lane-loaded instruction register, the register
// file, the operand, memory-data and ALU-result latches, and all
// steering muxes. Every select comes from an external controller;
// memory is outside. Assumes DATA_W = 8 with the fixed field layout.
module bytefetch_datapath
    import dp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREGS  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DATA_W-1:0]            mem_rdata,
    input  logic [IR_BYTES-1:0]          ir_we,
    input  logic                         pc_en,
    input  logic                         rf_we,
    input  logic                         rf_dst_rd,
    input  logic                         rf_src_mdr,
    input  logic                         addr_from_alu,
    input  logic                         opa_from_reg,
    input  logic [1:0]                   opb_sel,
    input  logic [1:0]                   pc_sel,
    input  logic [2:0]                   alu_op,
    output logic [DATA_W-1:0]            mem_addr,
    output logic [DATA_W-1:0]            mem_wdata,
    output logic [IR_BYTES*DATA_W-1:0]   instr,
    output logic                         zero
);

    logic [DATA_W-1:0]  pc_q, a_q, b_q, mdr_q, aluout_q;
    logic [DATA_W-1:0]  rd1, rd2, wr_data, opa, opb, alu_y;
    logic [DATA_W-1:0]  pc_nxt, jmp_addr, imm;
    logic [FIELD_W-1:0] rs_f, rt_f, rd_f, wr_idx;
    logic               alu_zero;

    dp_instr_reg #(.W(DATA_W), .LANES(IR_BYTES)) u_ir (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (ir_we),
        .din     (mem_rdata),
        .ir_q    (instr)
    );

    assign rs_f     = instr[RS_LSB +: FIELD_W];
    assign rt_f     = instr[RT_LSB +: FIELD_W];
    assign rd_f     = instr[RD_LSB +: FIELD_W];
    assign imm      = instr[DATA_W-1:0];
    assign jmp_addr = {instr[DATA_W-3:0], 2'b00};

    // Pick the destination register field.
    always_comb wr_idx = rf_dst_rd ? rd_f : rt_f;

    // Pick the register write data source.
    always_comb wr_data = rf_src_mdr ? mdr_q : aluout_q;

    dp_regfile #(.W(DATA_W), .NREGS(NREGS), .IDX_W(FIELD_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .wa    (wr_idx),
        .wd    (wr_data),
        .ra1   (rs_f),
        .ra2   (rt_f),
        .rd1   (rd1),
        .rd2   (rd2)
    );

    // Pick the first ALU operand.
    always_comb opa = opa_from_reg ? a_q : pc_q;

    // Pick the second ALU operand.
    always_comb begin
        case (opb_sel_e'(opb_sel))
            OPB_REG: opb = b_q;
            OPB_ONE: opb = DATA_W'(1);
            OPB_IMM: opb = imm;
            default: opb = imm << 2;
        endcase
    end

    dp_alu #(.W(DATA_W)) u_alu (
        .a    (opa),
        .b    (opb),
        .op   (alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Pick the next program counter value.
    always_comb begin
        case (pc_sel_e'(pc_sel))
            PCN_ALU: pc_nxt = alu_y;
            PCN_OUT: pc_nxt = aluout_q;
            PCN_JMP: pc_nxt = jmp_addr;
            default: pc_nxt = pc_q;
        endcase
    end

    // Program counter with load enable.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (pc_en) pc_q <= pc_nxt;
    end

    // Free-running operand, memory-data and ALU-result latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            mdr_q    <= '0;
            aluout_q <= '0;
        end else begin
            a_q      <= rd1;
            b_q      <= rd2;
            mdr_q    <= mem_rdata;
            aluout_q <= alu_y;
        end
    end

    assign mem_addr  = addr_from_alu ? aluout_q : pc_q;
    assign mem_wdata = b_q;
    assign zero      = alu_zero;

endmodule

// File: rtl/dp_checker.sv
// Temporal checks on the byte-fetch datapath, attached by bind.
// Assumes the field layout from dp_pkg.
module dp_checker
    import dp_pkg::*;
#(
    parameter int W     = 8,
    parameter int LANES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pc_en,
    input logic [1:0]         pc_sel,
    input logic [LANES-1:0]   ir_we,
    input logic [LANES*W-1:0] instr,
    input logic [W-1:0]       pc_q,
    input logic [W-1:0]       a_q,
    input logic [W-1:0]       rd2,
    input logic [W-1:0]       mem_wdata
);

    AST_PC_RESET: assert property (@(posedge clk) !rst_n |=> (pc_q == '0)); // R1

    AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_we == '0) |=> $stable(instr)); // R2

    AST_R0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[RS_LSB +: FIELD_W] == '0) |=> (a_q == '0)); // R3

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_en |=> $stable(pc_q)); // R10

    AST_PC_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_en && pc_sel == 2'b10) |=> (pc_q == {$past(instr[W-3:0]), 2'b00})); // R10

    AST_WDATA_B: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem_wdata == $past(rd2))); // R11

endmodule

bind bytefetch_datapath dp_checker #(.W(DATA_W), .LANES(IR_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_en     (pc_en),
    .pc_sel    (pc_sel),
    .ir_we     (ir_we),
    .instr     (instr),
    .pc_q      (pc_q),
    .a_q       (a_q),
    .rd2       (rd2),
    .mem_wdata (mem_wdata)
);

// File: tb/bytefetch_datapath_tb.sv
// Scoreboard bench: the driver queues expected port values for the
// coming edge, and the monitor compares them just after that edge.
module bytefetch_datapath_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  mem_rdata;
    logic [3:0]  ir_we;
    logic        pc_en, rf_we, rf_dst_rd, rf_src_mdr, addr_from_alu, opa_from_reg;
    logic [1:0]  opb_sel, pc_sel;
    logic [2:0]  alu_op;
    logic [7:0]  mem_addr, mem_wdata;
    logic [31:0] instr;
    logic        zero;

    typedef struct {
        int          kind;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    localparam int K_ADDR = 0, K_WDATA = 1, K_ZERO = 2, K_INSTR = 3;

    bytefetch_datapath u_dut (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .ir_we(ir_we),
        .pc_en(pc_en), .rf_we(rf_we), .rf_dst_rd(rf_dst_rd),
        .rf_src_mdr(rf_src_mdr), .addr_from_alu(addr_from_alu),
        .opa_from_reg(opa_from_reg), .opb_sel(opb_sel), .pc_sel(pc_sel),
        .alu_op(alu_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .instr(instr), .zero(zero)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic expect_val(input int kind, input logic [31:0] val, input string tag);
        exp_t e;
        e.kind = kind; e.val = val; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ctl_clear();
        ir_we = '0; pc_en = 0; rf_we = 0; rf_dst_rd = 0; rf_src_mdr = 0;
        addr_from_alu = 0; opa_from_reg = 1; opb_sel = 2'b10; pc_sel = 2'b00;
        alu_op = 3'b010; mem_rdata = '0;
    endtask

    // Load a word one lane per cycle with the PC frozen at pc_now.
    task automatic load_word(input logic [31:0] w, input logic [7:0] pc_now);
        for (int k = 0; k < 4; k++) begin
            ir_we = 4'(1 << k);
            mem_rdata = w[k*8 +: 8];
            pc_en = 0;
            addr_from_alu = 0;
            expect_val(K_ADDR, 32'(pc_now), "R10 pc held while pc_en low");
            tick();
        end
        ir_we = '0;
    endtask

    // Monitor: compare queued expectations just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                logic [31:0] act;
                e = q.pop_front();
                case (e.kind)
                    K_ADDR:  act = 32'(mem_addr);
                    K_WDATA: act = 32'(mem_wdata);
                    K_ZERO:  act = 32'(zero);
                    default: act = instr;
                endcase
                n_checks++;
                if (act !== e.val) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", e.tag, act, e.val);
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Driver.
    initial begin
        logic [31:0] w1, w2, w3;
        w1 = 32'h2003280C;  // rs=0 rt=3 rd=5 imm=0x0C
        w2 = 32'h00A30020;  // rs=5 rt=3 rd=0 imm=0x20
        w3 = 32'h0800000D;  // rs=0 rt=0 jump field 0x0D
        ctl_clear();
        rst_n = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        expect_val(K_ADDR, 32'h0, "R1 reset pc");
        expect_val(K_INSTR, 32'h0, "R1 reset instr");
        tick();
        rst_n = 1;

        // Fetch w1 with the PC stepping by PC+1.
        for (int k = 0; k < 4; k++) begin
            ir_we = 4'(1 << k); mem_rdata = w1[k*8 +: 8];
            pc_en = 1; pc_sel = 2'b00; opa_from_reg = 0; opb_sel = 2'b01; alu_op = 3'b010;
            addr_from_alu = 0;
            expect_val(K_ADDR, 32'(k + 1), "R6 R10 pc plus one");
            if (k == 3) expect_val(K_INSTR, w1, "R2 full word assembled");
            tick();
        end
        ctl_clear();
        tick();                                   // A=r0, B=r3 latched
        addr_from_alu = 1;
        expect_val(K_ADDR, 32'h0C, "R7 R9 immediate add");
        expect_val(K_WDATA, 32'h00, "R1 register reset value");
        tick();
        rf_we = 1; rf_dst_rd = 0; rf_src_mdr = 0;  // r3 <= 0x0C
        tick();
        rf_dst_rd = 1;                            // r5 <= 0x0C
        expect_val(K_WDATA, 32'h0C, "R4 R5 R11 rt write then B read");
        tick();
        rf_we = 0;

        // Load w2 with PC frozen at 4; check a partial word.
        ir_we = 4'b0001; mem_rdata = w2[7:0]; addr_from_alu = 0;
        expect_val(K_INSTR, 32'h20032820, "R2 single lane replaced");
        tick();
        for (int k = 1; k < 4; k++) begin
            ir_we = 4'(1 << k); mem_rdata = w2[k*8 +: 8];
            expect_val(K_ADDR, 32'h04, "R10 pc held while pc_en low");
            tick();
        end
        ir_we = '0;
        opa_from_reg = 1; opb_sel = 2'b00; alu_op = 3'b110;
        expect_val(K_ZERO, 32'h1, "R4 R8 rd write read back, sub zero");
        tick();
        opb_sel = 2'b01; mem_rdata = 8'h5A; addr_from_alu = 1;
        expect_val(K_ADDR, 32'h0B, "R7 R8 sub constant one");
        expect_val(K_ZERO, 32'h0, "R8 zero clear");
        tick();
        rf_we = 1; rf_dst_rd = 1; rf_src_mdr = 1;  // write to r0, dropped
        tick();
        rf_dst_rd = 0;                            // r3 <= MDR 0x5A
        tick();
        rf_we = 0;
        expect_val(K_WDATA, 32'h5A, "R5 memory data written back");
        tick();
        opb_sel = 2'b00; alu_op = 3'b000;
        expect_val(K_ADDR, 32'h08, "R8 and");
        tick();
        alu_op = 3'b001;
        expect_val(K_ADDR, 32'h5E, "R8 or");
        tick();
        alu_op = 3'b111;
        expect_val(K_ADDR, 32'h01, "R8 set less than true");
        tick();
        opb_sel = 2'b11;
        expect_val(K_ADDR, 32'h00, "R7 R8 signed compare vs 0x80");
        expect_val(K_ZERO, 32'h1, "R8 zero set");
        tick();
        alu_op = 3'b010;
        expect_val(K_ADDR, 32'h8C, "R7 shifted immediate add");
        tick();

        // Load w3, then check that r0 reads as zero.
        load_word(w3, 8'h04);
        opa_from_reg = 1; opb_sel = 2'b00; alu_op = 3'b010;
        expect_val(K_ZERO, 32'h1, "R3 register 0 reads zero");
        expect_val(K_WDATA, 32'h00, "R3 write to register 0 ignored");
        tick();

        // Next-PC sources.
        pc_en = 1; pc_sel = 2'b10; opa_from_reg = 0; opb_sel = 2'b11; addr_from_alu = 0;
        expect_val(K_ADDR, 32'h34, "R10 jump target");
        tick();
        pc_sel = 2'b01; opb_sel = 2'b01;
        expect_val(K_ADDR, 32'h38, "R9 R10 pc from ALU-result latch");
        tick();
        pc_en = 0; pc_sel = 2'b00;
        expect_val(K_ADDR, 32'h38, "R10 enable low holds pc");
        tick();
        pc_en = 1;
        expect_val(K_ADDR, 32'h39, "R10 pc from live result");
        tick();
        ctl_clear();
        tick();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule